// File: doc/BRIEF.md
# Composite Sync Separator

This block recovers a vertical sync pulse from a composite sync stream. It uses an up/down counter that integrates pulse width. The block runs on a slow, fixed sample clock and takes a composite sync bit whose polarity has already been normalized, so that 1 means a sync pulse is present. A short horizontal pulse lets the counter climb only a few steps before it drains back to zero. A long vertical pulse drives the count past a programmable threshold, and at that point the output asserts.

Once vertical sync is declared, the counter is cleared and reused to time the end of the vertical interval. Only inactive samples advance it. Active samples, such as serration or equalizing pulses, leave it frozen. The output drops when the inactive count reaches the same threshold. The counter value is also brought out so that it can be observed while debugging.

Top module: `csep_vsync_sep`

## Requirements
- R1: A synchronous reset clears the count to 0, drives `vsync_o` low, selects the search phase and empties the input synchronizer.
- R2: The input passes through a two-stage synchronizer. A level driven on `csync_i` takes part in the counter update on the third rising clock edge after it is applied.
- R3: In the search phase (`vsync_o` low), an active sample raises the count by one. An inactive sample lowers it by one, and the count does not go below 0.
- R4: The count saturates at 255 and never wraps. With a threshold of 255, the search phase can therefore never detect vertical sync.
- R5: In the search phase, `vsync_o` rises on the edge where the updated count would exceed the effective threshold, and on that same edge the count is cleared to 0. Starting from a count of 0, this takes exactly T+1 consecutive active samples. With T=8, horizontal pulses of 5 samples never assert the output.
- R6: In the release phase (`vsync_o` high), an inactive sample raises the count by one and an active sample leaves it unchanged.
- R7: In the release phase, `vsync_o` falls on the inactive sample at which the updated count reaches the effective threshold. On that edge the count is cleared to 0 and the block returns to the search phase.
- R8: A threshold input of 0 acts as 1. A single active sample from a count of 0 never asserts `vsync_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sample clock |
| rst_i | input | 1 | Synchronous reset, active high |
| csync_i | input | 1 | Composite sync, normalized so that 1 means active |
| thresh_i | input | CNT_W | Detection and release threshold T |
| vsync_o | output | 1 | Separated vertical sync, active high |
| count_o | output | CNT_W | Current integrator count, for debug |

## Verification
The assertions assume that `thresh_i` only changes while the count is small and the block is in the search phase. If it moved partway through an interval, the count could sit above the new limit, and the saturation and stepping properties would no longer describe a reachable case. The bench changes the threshold only at such quiet moments, either after a drain or during reset. It drives `csync_i` at falling edges so that each sample is a clean level. The assertions also expect the input to reach the counter only through the synchronizer. The bench therefore schedules every expected value three edges after the last sample it depends on.

// File: rtl/csep_pkg.sv
package csep_pkg;

   typedef enum logic {
      PH_SEARCH  = 1'b0,
      PH_RELEASE = 1'b1
   } csep_phase_e;

   typedef enum logic [1:0] {
      OP_HOLD = 2'd0,
      OP_UP   = 2'd1,
      OP_DOWN = 2'd2
   } csep_op_e;

endpackage

// File: rtl/csep_sync.sv
module csep_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic d_i,
   output logic q_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("csep_sync: STAGES must be at least 2");
      end

      if (STAGES == 2) begin : g_pair
         logic meta_q, sync_q;
         always_ff @(posedge clk_i) begin
            if (rst_i) begin
               meta_q <= 1'b0;
               sync_q <= 1'b0;
            end else begin
               meta_q <= d_i;
               sync_q <= meta_q;
            end
         end
         assign q_o = sync_q;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk_i) begin
            if (rst_i) chain_q <= '0;
            else       chain_q <= {chain_q[STAGES-2:0], d_i};
         end
         assign q_o = chain_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/csep_integrator.sv
module csep_integrator
   import csep_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  csep_op_e         op_i,
   input  logic             clr_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] step_o
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] step;

   // saturating step in both directions
   always_comb begin
      unique case (op_i)
         OP_UP:   step = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + CNT_ONE;
         OP_DOWN: step = (cnt_q == '0)      ? cnt_q : cnt_q - CNT_ONE;
         default: step = cnt_q;
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (rst_i)      cnt_q <= '0;
      else if (clr_i) cnt_q <= '0;
      else            cnt_q <= step;
   end

   assign cnt_o  = cnt_q;
   assign step_o = step;

endmodule

// File: rtl/csep_phase.sv
module csep_phase
   import csep_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             sync_i,
   input  logic [CNT_W-1:0] thr_i,
   input  logic [CNT_W-1:0] step_i,
   output csep_op_e         op_o,
   output logic             clr_o,
   output logic             vsync_o
);

   localparam logic [CNT_W-1:0] THR_FLOOR = CNT_W'(1);

   csep_phase_e      phase_q;
   logic [CNT_W-1:0] eff_thr;
   logic             hit;

   // a zero threshold is raised to one
   assign eff_thr = (thr_i == '0) ? THR_FLOOR : thr_i;

   always_comb begin
      if (phase_q == PH_SEARCH) begin
         op_o = sync_i ? OP_UP : OP_DOWN;
         hit  = (step_i > eff_thr);
      end else begin
         op_o = sync_i ? OP_HOLD : OP_UP;
         hit  = !sync_i && (step_i >= eff_thr);
      end
   end

   assign clr_o = hit;

   always_ff @(posedge clk_i) begin
      if (rst_i)    phase_q <= PH_SEARCH;
      else if (hit) phase_q <= (phase_q == PH_SEARCH) ? PH_RELEASE : PH_SEARCH;
   end

   assign vsync_o = (phase_q == PH_RELEASE);

   // R7: leaving release only happens on an inactive sample
   a_r7_exit_inactive: assert property (@(posedge clk_i) disable iff (rst_i)
      (phase_q == PH_RELEASE && sync_i) |=> (phase_q == PH_RELEASE));

endmodule

// File: rtl/csep_vsync_sep.sv
module csep_vsync_sep
   import csep_pkg::*;
#(
   parameter int CNT_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             csync_i,
   input  logic [CNT_W-1:0] thresh_i,
   output logic             vsync_o,
   output logic [CNT_W-1:0] count_o
);

   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("csep_vsync_sep: CNT_W must be at least 2");
      end
   endgenerate

   logic             sync_s;
   logic [CNT_W-1:0] step;
   csep_op_e         op;
   logic             clr;

   csep_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .d_i   (csync_i),
      .q_o   (sync_s)
   );

   csep_integrator #(.CNT_W(CNT_W)) u_integ (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .op_i   (op),
      .clr_i  (clr),
      .cnt_o  (count_o),
      .step_o (step)
   );

   csep_phase #(.CNT_W(CNT_W)) u_phase (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .sync_i  (sync_s),
      .thr_i   (thresh_i),
      .step_i  (step),
      .op_o    (op),
      .clr_o   (clr),
      .vsync_o (vsync_o)
   );

   // R3: an inactive sample in search drains the count by one
   a_r3_search_drain: assert property (@(posedge clk_i) disable iff (rst_i)
      (!vsync_o && !sync_s && count_o != '0) |=> (!vsync_o && count_o == $past(count_o) - 1'b1));

   // R4: counting up never wraps to zero unless a detection clears it
   a_r4_no_wrap: assert property (@(posedge clk_i) disable iff (rst_i)
      (!vsync_o && sync_s) |=> (count_o != '0 || vsync_o));

   // R5: detection clears the count
   a_r5_detect_clear: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(vsync_o) |-> (count_o == '0));

   // R6: serration pulses freeze the release count
   a_r6_serration_hold: assert property (@(posedge clk_i) disable iff (rst_i)
      (vsync_o && sync_s) |=> (vsync_o && $stable(count_o)));

   // R7: end of vertical sync clears the count
   a_r7_release_clear: assert property (@(posedge clk_i) disable iff (rst_i)
      $fell(vsync_o) |-> (count_o == '0));

   // R8: one active sample from an empty count never detects
   a_r8_no_single_sample: assert property (@(posedge clk_i) disable iff (rst_i)
      (!vsync_o && count_o == '0) |=> !vsync_o);

endmodule

// File: tb/csep_vsync_sep_test.sv
module csep_vsync_sep_test;

   localparam int CNT_W = 8;
   localparam int NSEG  = 19;
   localparam int QD    = 64;

   // table for T=8: level, length, expected count and vsync after the segment
   localparam int SEG_LVL [NSEG] = '{1, 0, 1, 0, 1, 0, 1, 1, 0, 1, 0, 1, 0, 0, 1, 0, 1, 0, 0};
   localparam int SEG_LEN [NSEG] = '{5,20, 5, 3, 5,10, 8, 1, 3, 2, 4, 1, 1, 5, 8, 1, 2, 7, 1};
   localparam int SEG_CNT [NSEG] = '{5, 0, 5, 2, 7, 0, 8, 0, 3, 3, 7, 7, 0, 0, 8, 7, 0, 7, 0};
   localparam int SEG_VS  [NSEG] = '{0, 0, 0, 0, 0, 0, 0, 1, 1, 1, 1, 1, 0, 0, 0, 0, 1, 1, 0};
   // rows: R5 R3 R3 R3 R5 R3 R5 R2 R6 R6 R6 R6 R7 R3 R5 R3 R5 R7 R7
   localparam int SEG_REQ [NSEG] = '{5, 3, 3, 3, 5, 3, 5, 2, 6, 6, 6, 6, 7, 3, 5, 3, 5, 7, 7};

   logic             clk = 1'b0;
   logic             rst;
   logic             csync;
   logic [CNT_W-1:0] thresh;
   logic             vsync;
   logic [CNT_W-1:0] count;

   int cyc = 0;
   int n_chk = 0;
   int n_fail = 0;
   int q_due [QD];
   int q_cnt [QD];
   int q_vs  [QD];
   int q_req [QD];
   int wr = 0;
   int rd = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   csep_vsync_sep #(.CNT_W(CNT_W), .SYNC_STAGES(2)) uut (
      .clk_i    (clk),
      .rst_i    (rst),
      .csync_i  (csync),
      .thresh_i (thresh),
      .vsync_o  (vsync),
      .count_o  (count)
   );

   task automatic check(input string req, input int act_c, input int exp_c,
                        input int act_v, input int exp_v);
      n_chk++;
      if (act_c != exp_c || act_v != exp_v) begin
         n_fail++;
         $display("FAIL %s: count=%0d vsync=%0d, expected count=%0d vsync=%0d",
                  req, act_c, act_v, exp_c, exp_v);
      end
   endtask

   // scheduled checks: an expectation becomes visible three edges after its last sample
   always @(negedge clk) begin
      while (rd < wr && q_due[rd % QD] == cyc) begin
         check($sformatf("R%0d", q_req[rd % QD]), int'(count), q_cnt[rd % QD],
               int'(vsync), q_vs[rd % QD]);
         rd++;
      end
   end

   task automatic run_seg(input int lvl, input int len, input int ec, input int ev, input int req);
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         csync = lvl[0];
      end
      q_due[wr % QD] = cyc + 3;
      q_cnt[wr % QD] = ec;
      q_vs[wr % QD]  = ev;
      q_req[wr % QD] = req;
      wr++;
   endtask

   task automatic drain();
      while (rd != wr) @(negedge clk);
   endtask

   task automatic do_reset(input string req);
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      check(req, int'(count), 0, int'(vsync), 0);
      csync = 1'b0;
      @(negedge clk);
      rst = 1'b0;
   endtask

   initial begin
      rst    = 1'b1;
      csync  = 1'b0;
      thresh = 8'd8;
      repeat (3) @(negedge clk);
      check("R1", int'(count), 0, int'(vsync), 0);
      rst = 1'b0;

      // table walk, T=8: hsync rejection, detect at T+1, serrated release after T
      for (int s = 0; s < NSEG; s++)
         run_seg(SEG_LVL[s], SEG_LEN[s], SEG_CNT[s], SEG_VS[s], SEG_REQ[s]);
      run_seg(0, 1, 0, 0, 3);
      drain();

      // R4: saturation at 255, threshold 255 never detects
      thresh = 8'd255;
      run_seg(1, 300, 255, 0, 4);
      run_seg(0, 3, 252, 0, 4);
      drain();
      do_reset("R1");

      // R8: zero threshold acts as one
      thresh = 8'd0;
      run_seg(1, 1, 1, 0, 8);
      run_seg(1, 1, 0, 1, 8);
      run_seg(0, 1, 0, 0, 8);
      run_seg(0, 2, 0, 0, 3);
      drain();

      // R1: reset in the middle of the release phase
      thresh = 8'd4;
      run_seg(1, 5, 0, 1, 5);
      run_seg(0, 2, 2, 1, 6);
      drain();
      do_reset("R1");
      repeat (4) @(negedge clk);
      check("R1", int'(count), 0, int'(vsync), 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule